// File: doc/BRIEF.md
# DC-Balanced Parallel Frame Encoder

This block sits on the transmit side of a gigabit serial link, between the parallel user interface and the serializer. On every frame-clock edge it captures one word, either a data word with an optional flag bit or a control word, and builds a complete frame from it: a data field plus a 4-bit coding field. The coding field tells the far end whether the frame holds data, control or idle fill, and whether it was sent inverted. The whole frame is present in parallel before its sign is worked out.

The block keeps a signed running total of ones minus zeros over every bit it has already sent. When a new frame has the same sign as that total, the whole frame, coding field included, is complemented, so that the line stays DC balanced. A narrow mode packs 16 data bits into a 20-bit frame, and a wide mode packs 20 data bits into a 24-bit frame. The mode is chosen frame by frame. Data and control words are only accepted once the clock source reports lock and the link is enabled. Until then, and whenever nothing is offered, the block sends a balanced idle frame.

Top module: `dcbal_frame_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, `frame_out` becomes all zeros and both `frame_valid` and `tx_ready` become 0. The running total restarts at zero, so the first frame after reset is never complemented.
- R2: `tx_ready` is 1 in the cycle after an edge at which both `pll_locked` and `tx_enable` were 1, and 0 after any other edge.
- R3: Frame choice at an edge, highest priority first: an idle frame if `tx_ready` is 0 or `fill_req` is 1; otherwise a data frame if `data_avail` is 1; otherwise a control frame if `ctrl_avail` is 1; otherwise an idle frame.
- R4: Before any inversion, a data frame holds the data word in the low bits (16 bits in narrow mode, 20 bits in wide mode). The 4 bits directly above it are the coding field: 1101 when `flag_in` is 0 and 1011 when `flag_in` is 1.
- R5: Before any inversion, a control frame holds the control word in the low bits (14 bits narrow, 18 bits wide). Above it sit the lead bits 01, and above those the coding field 0011.
- R6: An idle frame has coding field 0011 and lead bits 10. Its body is 14 bits (narrow) or 18 bits (wide), with bit i equal to 1 exactly when i is odd. It therefore has zero disparity.
- R7: A frame's disparity is its count of ones minus its count of zeros over the active width (20 or 24 bits). The frame is complemented over that width when its disparity and the running total are both positive or both negative. Otherwise it is sent unchanged.
- R8: After each frame the running total grows by the disparity of the frame as actually sent. A zero-disparity frame is never complemented and leaves the total unchanged. The total's magnitude never exceeds 24.
- R9: In narrow mode, bits 23:20 of `frame_out` are 0. The coding field occupies bits 19:16 and the lead bits occupy bits 15:14. In wide mode these fields sit at bits 23:20 and 19:18.
- R10: No frame is sent whose coding field has its two middle bits equal (x00x or x11x), or equals 1010 or 0101. Coding field 1100 only appears when the lead bits are 10.
- R11: `frame_valid` is 1 after every clock edge at which `rst` was low, giving one frame per frame-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_locked | input | 1 | Clock source reports lock |
| tx_enable | input | 1 | Link enable from the user |
| wide_mode | input | 1 | 1: 20-bit data in a 24-bit frame; 0: 16-bit data in a 20-bit frame |
| flag_in | input | 1 | Extra flag bit carried in a data frame's coding field |
| data_avail | input | 1 | A data word is offered this cycle |
| ctrl_avail | input | 1 | A control word is offered this cycle |
| fill_req | input | 1 | Forces an idle frame this cycle |
| data_in | input | 20 | Data word; narrow mode uses bits 15:0 |
| ctrl_in | input | 18 | Control word; narrow mode uses bits 13:0 |
| tx_ready | output | 1 | Link ready to accept data and control words |
| frame_valid | output | 1 | `frame_out` holds a frame |
| frame_out | output | 24 | Encoded frame, ready for serialization |

## Verification
All 32 combinations of lock, enable, fill request, data-available and control-available are swept in both modes against a bench model. This separates the choice of frame type and the ready timing from the encoding itself. Data words of all zeros, all ones and walking ones give frames with large disparity of either sign. These show whether the complement decision and the running-total update track the sign rule. Long runs of all-ones frames in wide mode make the total swing and force repeated inversions, including the complemented control code with its lead bits. Balanced data words and idle frames, sent while the total is non-zero, show that zero-disparity frames are never complemented. A reset in the middle of the run shows the total restarting at zero.

// File: rtl/dcbal_pkg.sv
package dcbal_pkg;

  localparam int CODE_W = 4;
  localparam int LEAD_W = 2;

  typedef enum logic [1:0] {
    KIND_FILL = 2'd0,
    KIND_DATA = 2'd1,
    KIND_CTRL = 2'd2
  } frame_kind_e;

  localparam logic [CODE_W-1:0] CODE_DATA_F0 = 4'b1101;
  localparam logic [CODE_W-1:0] CODE_DATA_F1 = 4'b1011;
  localparam logic [CODE_W-1:0] CODE_CTRL    = 4'b0011;
  localparam logic [LEAD_W-1:0] LEAD_CTRL    = 2'b01;
  localparam logic [LEAD_W-1:0] LEAD_FILL    = 2'b10;

endpackage

// File: rtl/dcbal_frame_builder.sv
module dcbal_frame_builder
  import dcbal_pkg::*;
#(
  parameter int DW = 16,
  localparam int BODY_W = DW - LEAD_W,
  localparam int FW = DW + CODE_W
) (
  input  frame_kind_e       kind,
  input  logic              flag,
  input  logic [DW-1:0]     data,
  input  logic [BODY_W-1:0] ctrl,
  output logic [FW-1:0]     frame
);

  logic [BODY_W-1:0] idle_body;

  always_comb begin
    for (int i = 0; i < BODY_W; i++) idle_body[i] = (i % 2) == 1;
  end

  always_comb begin
    unique case (kind)
      KIND_DATA: frame = {(flag ? CODE_DATA_F1 : CODE_DATA_F0), data};
      KIND_CTRL: frame = {CODE_CTRL, LEAD_CTRL, ctrl};
      default:   frame = {CODE_CTRL, LEAD_FILL, idle_body};
    endcase
  end

endmodule

// File: rtl/dcbal_disparity_calc.sv
module dcbal_disparity_calc #(
  parameter int FW = 24,
  localparam int CNT_W = $clog2(FW + 1),
  localparam int DISP_W = CNT_W + 2
) (
  input  logic [FW-1:0]            frame,
  input  logic [CNT_W-1:0]         active_bits,
  output logic signed [DISP_W-1:0] disp
);

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < FW; i++) ones = ones + CNT_W'(frame[i]);
    disp = $signed({1'b0, ones, 1'b0}) - $signed({2'b00, active_bits});
  end

endmodule

// File: rtl/dcbal_frame_encoder.sv
module dcbal_frame_encoder
  import dcbal_pkg::*;
#(
  parameter int NARROW_DW = 16,
  parameter int WIDE_DW = 20,
  localparam int FW_N = NARROW_DW + CODE_W,
  localparam int FW_W = WIDE_DW + CODE_W,
  localparam int CTRL_W = WIDE_DW - LEAD_W,
  localparam int CNT_W = $clog2(FW_W + 1),
  localparam int DISP_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pll_locked,
  input  logic              tx_enable,
  input  logic              wide_mode,
  input  logic              flag_in,
  input  logic              data_avail,
  input  logic              ctrl_avail,
  input  logic              fill_req,
  input  logic [WIDE_DW-1:0] data_in,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic              tx_ready,
  output logic              frame_valid,
  output logic [FW_W-1:0]   frame_out
);

  localparam logic [FW_W-1:0] MASK_N = {{(FW_W-FW_N){1'b0}}, {FW_N{1'b1}}};
  localparam logic [CNT_W-1:0] ACT_N = CNT_W'(FW_N);
  localparam logic [CNT_W-1:0] ACT_W = CNT_W'(FW_W);

  frame_kind_e kind;
  logic [FW_W-1:0] raw_frame, frame_next, act_mask;
  logic signed [DISP_W-1:0] disp, rd_q, rd_next;
  logic disp_pos, disp_neg, rd_pos, rd_neg, invert;
  logic wide_q;

  // Frame type selection, ready has priority over all requests
  always_comb begin
    if (!tx_ready || fill_req) kind = KIND_FILL;
    else if (data_avail)       kind = KIND_DATA;
    else if (ctrl_avail)       kind = KIND_CTRL;
    else                       kind = KIND_FILL;
  end

  // One builder per frame width; mode picks which one is used
  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int DW = (g == 0) ? NARROW_DW : WIDE_DW;
    logic [DW+CODE_W-1:0] part;
    dcbal_frame_builder #(.DW(DW)) u_build (
      .kind (kind),
      .flag (flag_in),
      .data (data_in[DW-1:0]),
      .ctrl (ctrl_in[DW-LEAD_W-1:0]),
      .frame(part)
    );
  end

  always_comb begin
    if (wide_mode) raw_frame = g_width[1].part;
    else           raw_frame = FW_W'(g_width[0].part);
    act_mask = wide_mode ? '1 : MASK_N;
  end

  dcbal_disparity_calc #(.FW(FW_W)) u_disp (
    .frame      (raw_frame),
    .active_bits(wide_mode ? ACT_W : ACT_N),
    .disp       (disp)
  );

  always_comb begin
    disp_neg   = disp[DISP_W-1];
    disp_pos   = !disp_neg && (disp != '0);
    rd_neg     = rd_q[DISP_W-1];
    rd_pos     = !rd_neg && (rd_q != '0);
    invert     = (disp_pos && rd_pos) || (disp_neg && rd_neg);
    frame_next = invert ? (raw_frame ^ act_mask) : raw_frame;
    rd_next    = invert ? (rd_q - disp) : (rd_q + disp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q        <= '0;
      frame_out   <= '0;
      frame_valid <= 1'b0;
      tx_ready    <= 1'b0;
      wide_q      <= 1'b0;
    end else begin
      rd_q        <= rd_next;
      frame_out   <= frame_next;
      frame_valid <= 1'b1;
      tx_ready    <= pll_locked && tx_enable;
      wide_q      <= wide_mode;
    end
  end

  // Fields of the frame just sent, located by the mode it was sent in
  logic [CODE_W-1:0] code_seen;
  logic [LEAD_W-1:0] lead_seen;
  always_comb begin
    if (wide_q) begin
      code_seen = frame_out[FW_W-1 -: CODE_W];
      lead_seen = frame_out[FW_W-CODE_W-1 -: LEAD_W];
    end else begin
      code_seen = frame_out[FW_N-1 -: CODE_W];
      lead_seen = frame_out[FW_N-CODE_W-1 -: LEAD_W];
    end
  end

  // R2
  ready_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (pll_locked && tx_enable) |=> tx_ready);
  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !(pll_locked && tx_enable) |=> !tx_ready);
  // R11
  valid_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> frame_valid);
  // R7
  pos_total_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pos |=> (rd_q <= $past(rd_q)));
  // R7
  neg_total_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
    rd_neg |=> (rd_q >= $past(rd_q)));
  // R8
  zero_disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (disp == '0) |=> $stable(rd_q));
  // R8
  total_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_q) <= FW_W) && (int'(rd_q) >= -FW_W));
  // R9
  narrow_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !wide_q) |-> (frame_out[FW_W-1:FW_N] == '0));
  // R10
  code_middle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (code_seen[2] != code_seen[1]));
  // R10
  code_alt_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (code_seen != 4'b1010 && code_seen != 4'b0101));
  // R10
  code_1100_lead_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && code_seen == 4'b1100) |-> (lead_seen == 2'b10));

endmodule

// File: tb/dcbal_frame_encoder_tb.sv
`timescale 1ns/100ps
module dcbal_frame_encoder_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pll_locked = 0, tx_enable = 0, wide_mode = 0, flag_in = 0;
  logic data_avail = 0, ctrl_avail = 0, fill_req = 0;
  logic [19:0] data_in = '0;
  logic [17:0] ctrl_in = '0;
  logic tx_ready, frame_valid;
  logic [23:0] frame_out;

  int checks = 0;
  int failures = 0;
  int rd_m = 0;
  bit rdy_m = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dcbal_frame_encoder u_dut (
    .clk(clk), .rst(rst), .pll_locked(pll_locked), .tx_enable(tx_enable),
    .wide_mode(wide_mode), .flag_in(flag_in), .data_avail(data_avail),
    .ctrl_avail(ctrl_avail), .fill_req(fill_req), .data_in(data_in),
    .ctrl_in(ctrl_in), .tx_ready(tx_ready), .frame_valid(frame_valid),
    .frame_out(frame_out)
  );

  task automatic check(bit ok, string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Frame before inversion, built from the layouts in R4, R5, R6, R9
  function automatic logic [23:0] expect_raw(bit w, int kind, bit fl,
                                             logic [19:0] d, logic [17:0] c);
    logic [23:0] f = '0;
    int bw = w ? 18 : 14;
    int cpos = w ? 20 : 16;
    logic [3:0] code;
    logic [1:0] lead;
    if (kind == 1) begin
      code = fl ? 4'b1011 : 4'b1101;
      for (int i = 0; i < cpos; i++) f[i] = d[i];
    end else begin
      code = 4'b0011;
      lead = (kind == 2) ? 2'b01 : 2'b10;
      for (int i = 0; i < bw; i++) f[i] = (kind == 2) ? c[i] : ((i % 2) == 1);
      f[bw] = lead[0];
      f[bw+1] = lead[1];
    end
    for (int i = 0; i < 4; i++) f[cpos+i] = code[i];
    return f;
  endfunction

  task automatic step(bit w, bit lk, bit en, bit ff, bit dv, bit cv, bit fl,
                      logic [19:0] d, logic [17:0] c);
    int kind, disp, fw;
    bit inv;
    logic [23:0] raw, exp, mask;
    logic [3:0] code;
    logic [1:0] lead;
    string tag;
    wide_mode = w; pll_locked = lk; tx_enable = en; fill_req = ff;
    data_avail = dv; ctrl_avail = cv; flag_in = fl; data_in = d; ctrl_in = c;
    // R3 selection uses the ready state from before this edge
    if (!rdy_m || ff) kind = 0;
    else if (dv) kind = 1;
    else if (cv) kind = 2;
    else kind = 0;
    fw = w ? 24 : 20;
    mask = w ? 24'hFFFFFF : 24'h0FFFFF;
    raw = expect_raw(w, kind, fl, d, c);
    disp = 2 * $countones(raw) - fw;
    inv = (disp > 0 && rd_m > 0) || (disp < 0 && rd_m < 0);
    exp = inv ? (raw ^ mask) : raw;
    rd_m = rd_m + (inv ? -disp : disp);
    tag = (kind == 1) ? "R3 R4" : (kind == 2) ? "R3 R5" : "R3 R6";
    if (inv) tag = {tag, " R7"};
    if (disp == 0) tag = {tag, " R8"};
    @(negedge clk);
    check(frame_out == exp, tag, frame_out, exp);
    check(frame_valid == 1'b1, "R11", 24'(frame_valid), 24'd1);
    check(tx_ready == (lk && en), "R2", 24'(tx_ready), 24'(lk && en));
    rdy_m = lk && en;
    if (!w) check(frame_out[23:20] == 4'h0, "R9", frame_out, exp);
    code = w ? frame_out[23:20] : frame_out[19:16];
    lead = w ? frame_out[19:18] : frame_out[15:14];
    check((code[2] != code[1]) && code != 4'b1010 && code != 4'b0101 &&
          (code != 4'b1100 || lead == 2'b10), "R10", 24'(code), 24'(lead));
  endtask

  function automatic logic [19:0] pattern(int k);
    case (k)
      0: return 20'h00000;
      1: return 20'hFFFFF;
      2: return 20'h0007F;
      3: return 20'h0FFFF;
      default: return 20'(1 << (k % 20)) ^ 20'($urandom);
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(frame_out == '0, "R1", frame_out, 24'h0);
    check(frame_valid == 1'b0, "R1", 24'(frame_valid), 24'h0);
    check(tx_ready == 1'b0, "R1", 24'(tx_ready), 24'h0);
    rst = 1'b0;
    rd_m = 0;
    rdy_m = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // Sweep every control-input combination in both modes
    for (int w = 0; w < 2; w++)
      for (int sel = 0; sel < 32; sel++)
        for (int k = 0; k < 8; k++)
          step(w[0], sel[0], sel[1], sel[2], sel[3], sel[4], k[0],
               pattern(k), 18'($urandom));
    // R7: long same-sign runs force repeated inversions
    for (int i = 0; i < 12; i++) step(1, 1, 1, 0, 1, 0, 0, 20'hFFFFF, '0);
    for (int i = 0; i < 12; i++) step(1, 1, 1, 0, 0, 1, 0, '0, 18'h3FFFF);
    for (int i = 0; i < 12; i++) step(0, 1, 1, 0, 0, 1, 0, '0, 18'h00000);
    // R8: balanced frames while the total is off zero
    step(0, 1, 1, 0, 1, 0, 0, 20'hFFFFF, '0);
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 1, 0, 0, 20'h0007F, '0);
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 1, 0, 0, 20'hFFFFF, '0);
    // Mixed random traffic
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom;
      step(r[0], 1, r[1] | r[2], r[3] & r[4], r[5], r[6], r[7],
           20'($urandom), 18'($urandom));
    end
    // R1: reset mid-run restarts the running total
    do_reset();
    for (int i = 0; i < 6; i++) step(1, 1, 1, 0, 1, 0, 0, 20'hFFFFF, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule